// File: doc/BRIEF.md
# Triangle-Carrier Complementary PWM

This block turns an unsigned duty command into a pair of opposite-polarity switching signals for a power stage. An up/down counter forms a symmetric triangular carrier. It climbs from zero to its top value and falls back to zero. A comparator checks the carrier level against the active duty on every clock. One output is high while the carrier is at or above the duty. The other output is high while the carrier is below it.

The duty input is captured whenever its valid strobe is high, but it takes effect only at a carrier period boundary. An update therefore never cuts into a period already in progress. The carrier holds each turning point for two clocks, so one period lasts 2·(MAX+1) clocks. With an 8-bit counter and a 25 MHz clock this gives about 48.83 kHz. A one-clock marker flags the first clock of every period.

Top module: `triangle_pwm`

## Requirements
- R1: After reset, the period marker is high, `pwm_hi` is 1 and `pwm_lo` is 0. The reset value of the active duty is 0.
- R2: The carrier runs through 0,1,…,MAX,MAX,MAX−1,…,0,0 and then repeats. A period is therefore 2·(MAX+1) clocks, which is 512 for the default 8-bit width. `period_start` is high for exactly the first clock of each period.
- R3: In every clock exactly one of `pwm_hi` and `pwm_lo` is high.
- R4: For an active duty d, `pwm_hi` is high for 2·(MAX+1−d) clocks of each period. This high time is one contiguous run that starts at clock offset d after `period_start` and ends at offset 2·MAX+1−d, so it is centred on the peak.
- R5: A duty strobed in the middle of a period does not change that period. It becomes active from the next `period_start`.
- R6: A duty of 0 keeps `pwm_hi` high for the whole period. A duty of MAX gives `pwm_hi` for only the two peak clocks.
- R7: If the duty is strobed more than once within a period, the last strobe wins. This includes a strobe in the last clock of the period, which takes effect at the very next period.
- R8: The `duty` input has no effect while `duty_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst | input | 1 | Synchronous active-high reset |
| duty | input | 8 | Unsigned duty command |
| duty_vld | input | 1 | Duty capture strobe |
| pwm_hi | output | 1 | High while carrier ≥ active duty |
| pwm_lo | output | 1 | High while carrier < active duty |
| period_start | output | 1 | One-clock marker on the first clock of each period |

## Verification
The assertions check the following on every clock:
- the carrier steps by one;
- each turning point is held for exactly two clocks;
- the wrap from the bottom of the carrier leads straight into a period start;
- the active duty stays frozen away from the period boundary;
- a pending strobe is remembered;
- the two outputs stay complementary.

The bench shows the things that only full periods can reveal. It measures the high time and its position within each period for a range of duty values, including both extremes. It also covers what happens when several strobes fall into one period or one falls in its final clock, and it confirms that the duty bus is ignored while the strobe is low.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int PWM_W = 8;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    localparam int PERIOD_CLKS = 2 * (1 << PWM_W);
endpackage

// File: rtl/pwm_carrier.sv
module pwm_carrier
    import pwm_pkg::*;
#(
    parameter int W = PWM_W
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] level,
    output dir_e         dir,
    output logic         start,
    output logic         wrap
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
            dir   <= DIR_UP;
        end else begin
            case (dir)
                DIR_UP: begin
                    if (level == TOP) dir <= DIR_DOWN;
                    else              level <= level + 1'b1;
                end
                default: begin
                    if (level == '0) dir <= DIR_UP;
                    else             level <= level - 1'b1;
                end
            endcase
        end
    end

    assign start = (dir == DIR_UP)   && (level == '0);
    assign wrap  = (dir == DIR_DOWN) && (level == '0);

    // R2: the carrier rises one step per clock below the peak
    assert_step_up_R2: assert property (@(posedge clk) disable iff (rst)
        (dir == DIR_UP && level != TOP) |=> (level == W'($past(level) + 1'b1)));

    // R2: the peak is held for a second clock while the direction turns
    assert_peak_turn_R2: assert property (@(posedge clk) disable iff (rst)
        (dir == DIR_UP && level == TOP) |=> (dir == DIR_DOWN && level == TOP));

    // R2: the last clock at zero is followed by a new period
    assert_wrap_start_R2: assert property (@(posedge clk) disable iff (rst)
        wrap |=> start);
endmodule

// File: rtl/pwm_duty_hold.sv
module pwm_duty_hold #(
    parameter int W = pwm_pkg::PWM_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe,
    input  logic [W-1:0] duty_in,
    input  logic         wrap,
    output logic [W-1:0] duty_act
);
    logic [W-1:0] shadow;
    logic         pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_act <= '0;
            shadow   <= '0;
            pend     <= 1'b0;
        end else if (wrap) begin
            duty_act <= strobe ? duty_in : (pend ? shadow : duty_act);
            pend     <= 1'b0;
        end else if (strobe) begin
            shadow <= duty_in;
            pend   <= 1'b1;
        end
    end

    // R5: the active duty only changes across a period boundary
    assert_duty_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(duty_act));

    // R7: a strobe away from the boundary is kept pending with its value
    assert_pend_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (strobe && !wrap) |=> (pend && shadow == $past(duty_in)));
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
    parameter int W = pwm_pkg::PWM_W
) (
    input  logic [W-1:0] level,
    input  logic [W-1:0] duty_act,
    output logic         at_or_above,
    output logic         below
);
    always_comb begin
        at_or_above = (level >= duty_act);
        below       = (level <  duty_act);
    end
endmodule

// File: rtl/triangle_pwm.sv
module triangle_pwm
    import pwm_pkg::*;
#(
    parameter int W = PWM_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] duty,
    input  logic         duty_vld,
    output logic         pwm_hi,
    output logic         pwm_lo,
    output logic         period_start
);
    logic [W-1:0] level;
    logic [W-1:0] duty_act;
    dir_e         dir;
    logic         wrap;

    pwm_carrier #(.W(W)) carrier_i (
        .clk   (clk),
        .rst   (rst),
        .level (level),
        .dir   (dir),
        .start (period_start),
        .wrap  (wrap)
    );

    pwm_duty_hold #(.W(W)) hold_i (
        .clk      (clk),
        .rst      (rst),
        .strobe   (duty_vld),
        .duty_in  (duty),
        .wrap     (wrap),
        .duty_act (duty_act)
    );

    pwm_compare #(.W(W)) cmp_i (
        .level       (level),
        .duty_act    (duty_act),
        .at_or_above (pwm_hi),
        .below       (pwm_lo)
    );

    // R3: the two outputs are always of opposite polarity
    assert_compl_R3: assert property (@(posedge clk) disable iff (rst)
        pwm_hi != pwm_lo);

    // R2: a period start is only ever entered from the bottom of a falling carrier
    assert_start_src_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(period_start) |-> ($past(level) == '0 && $past(dir) == DIR_DOWN));
endmodule

// File: tb/triangle_pwm_tb_top.sv
module triangle_pwm_tb_top;
    localparam int CLK_P  = 40;
    localparam int PER    = 512;
    localparam int NVEC   = 8;
    localparam logic [7:0] DUTY_TAB [NVEC] = '{8'd0, 8'd1, 8'd64, 8'd127,
                                               8'd128, 8'd200, 8'd254, 8'd255};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] duty = '0;
    logic       duty_vld = 1'b0;
    logic       pwm_hi, pwm_lo, period_start;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    int m_hi, m_first, m_last, m_starts, m_compl;

    always #(CLK_P/2) clk = ~clk;

    triangle_pwm dut_i (
        .clk          (clk),
        .rst          (rst),
        .duty         (duty),
        .duty_vld     (duty_vld),
        .pwm_hi       (pwm_hi),
        .pwm_lo       (pwm_lo),
        .period_start (period_start)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_start();
        for (int i = 0; i < PER + 4; i++) begin
            if (period_start) return;
            @(negedge clk);
        end
    endtask

    task automatic strobe(input logic [7:0] v);
        duty     = v;
        duty_vld = 1'b1;
        @(negedge clk);
        duty_vld = 1'b0;
        duty     = 8'hA5;  // R8: bus noise while the strobe is low
    endtask

    // Called at a negedge where period_start is high; measures one period.
    task automatic measure(input int ia, input logic [7:0] va,
                           input int ib, input logic [7:0] vb);
        m_hi = 0; m_first = -1; m_last = -1; m_starts = 0; m_compl = 0;
        for (int k = 0; k < PER; k++) begin
            if (k == ia) begin duty = va; duty_vld = 1'b1; end
            else if (k == ib) begin duty = vb; duty_vld = 1'b1; end
            else begin duty_vld = 1'b0; duty = 8'h5A; end
            if (pwm_hi) begin
                m_hi++;
                if (m_first < 0) m_first = k;
                m_last = k;
            end
            if (pwm_hi == pwm_lo) m_compl++;
            if (period_start) m_starts++;
            @(negedge clk);
        end
        duty_vld = 1'b0;
    endtask

    task automatic expect_period(input int d, input string tag);
        chk(m_hi == 2*(256-d), {tag, " R4 high time"}, m_hi, 2*(256-d));
        chk(m_first == d, {tag, " R4 first high offset"}, m_first, d);
        chk(m_last == PER-1-d, {tag, " R4 last high offset"}, m_last, PER-1-d);
        chk(m_compl == 0, {tag, " R3 complement"}, m_compl, 0);
        chk(m_starts == 1, {tag, " R2 one marker"}, m_starts, 1);
        chk(period_start == 1'b1, {tag, " R2 period length"}, period_start, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state, sampled just after reset releases
        chk(period_start == 1'b1, "R1 marker", period_start, 1);
        chk(pwm_hi == 1'b1, "R1 pwm_hi", pwm_hi, 1);
        chk(pwm_lo == 1'b0, "R1 pwm_lo", pwm_lo, 0);
        measure(-1, 8'd0, -1, 8'd0);
        expect_period(0, "reset duty");

        // Table walk: R4 and R6 (0 and 255 are the extremes)
        for (int v = 0; v < NVEC; v++) begin
            strobe(DUTY_TAB[v]);
            wait_start();
            measure(-1, 8'd0, -1, 8'd0);
            expect_period(int'(DUTY_TAB[v]), $sformatf("R6/table duty=%0d", DUTY_TAB[v]));
        end

        // R5: a mid-period strobe leaves the current period at 64
        strobe(8'd64);
        wait_start();
        measure(100, 8'd200, -1, 8'd0);
        expect_period(64, "R5 current period");
        measure(-1, 8'd0, -1, 8'd0);
        expect_period(200, "R5 next period");

        // R7: last strobe wins, including one in the final clock
        measure(300, 8'd10, 505, 8'd90);
        expect_period(200, "R7 unchanged period");
        measure(511, 8'd50, -1, 8'd0);
        expect_period(90, "R7 last of two");
        measure(-1, 8'd0, -1, 8'd0);
        expect_period(50, "R7 final-clock strobe");

        // R8: the duty bus toggles with the strobe low; the duty stays 50
        measure(-1, 8'd0, -1, 8'd0);
        expect_period(50, "R8 bus ignored");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule